// File: doc/BRIEF.md
# Status Flags and Branch Condition Unit

This block holds the eight condition flags of a small microcontroller core and decides where control goes next. The flag register takes masked flag results from the ALU. It also takes single-flag set and clear commands by index, copies a register bit into the transfer flag, and raises the interrupt-enable flag when an interrupt handler returns. A bit-load path puts the transfer flag back into any bit of a register value.

On the control side, one indexed flag test with a polarity covers every conditional branch. Equal, carry, sign, overflow, half-carry, transfer, interrupt and signed compares all use it; signed compares test the stored sign flag, which the ALU writes as N xor V. Register-bit, I/O-bit and compare-equal skips use the same output path. The block returns a taken indication, the next program counter and the number of cycles the instruction spends.

Top module: `sreg_branch_unit`

## Requirements
- R1: After reset all eight flags (`sreg`) read 0.
- R2: Flag bits from 7 down to 0 are I, T, H, S, V, N, Z, C. When `alu_we` is high, each flag whose `alu_mask` bit is 1 takes the matching `alu_flags` bit at the next clock edge, and the other flags hold.
- R3: When `bit_op_en` is high, flag `bit_op_idx` becomes `bit_op_set` at the next edge. This overrides an ALU update, a bit store or an interrupt return on the same flag in the same cycle.
- R4: When `tst_en` is high, flag T (bit 6) takes bit `tst_bit` of `tst_reg` at the next edge.
- R5: `blt_out` equals `blt_reg` with bit `blt_bit` replaced by the current T flag, and the bit-load path changes no flag.
- R6: When `reti_en` is high, flag I (bit 7) is 1 after the next edge.
- R7: With `req_kind` = 2'b01 (branch), the branch is taken when flag `br_idx` equals `br_pol`. `pc_next` is then `pc_in` + sign-extended 7-bit `br_off` + 1, modulo 2^PCW. When the branch is not taken, `pc_next` is `pc_in` + 1.
- R8: A taken branch reports `cycles` = 2 and a branch that is not taken reports `cycles` = 1.
- R9: With `req_kind` = 2'b10, the skip condition is bit `skp_bit` of `skp_reg` equal to `skp_pol`. With `req_kind` = 2'b11, the skip condition is `cmp_a` equal to `cmp_b`.
- R10: A skip whose condition holds sets `taken`. It advances `pc_next` by 2 with `cycles` = 2 when `next_is_long` is 0, and by 3 with `cycles` = 3 when `next_is_long` is 1. A skip whose condition fails advances by 1 with `cycles` = 1.
- R11: With `req_kind` = 2'b00, `taken` is 0, `pc_next` is `pc_in` + 1 and `cycles` is 1.
- R12: The flags hold their value in any cycle where none of `alu_we`, `bit_op_en`, `tst_en` or `reti_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_we | input | 1 | Apply masked ALU flag update |
| alu_mask | input | 8 | Flags touched by the ALU update |
| alu_flags | input | 8 | New flag values from the ALU |
| bit_op_en | input | 1 | Single-flag set/clear command |
| bit_op_set | input | 1 | Value written by the command |
| bit_op_idx | input | 3 | Flag index for the command |
| tst_en | input | 1 | Copy a register bit into T |
| tst_reg | input | 8 | Register value for the bit store |
| tst_bit | input | 3 | Bit position for the bit store |
| reti_en | input | 1 | Interrupt return: set I |
| blt_reg | input | 8 | Register value for the bit load |
| blt_bit | input | 3 | Bit position for the bit load |
| blt_out | output | 8 | Register value with T inserted |
| req_kind | input | 2 | 00 none, 01 branch, 10 bit skip, 11 equal skip |
| br_idx | input | 3 | Flag tested by a branch |
| br_pol | input | 1 | Flag value that takes the branch |
| br_off | input | 7 | Signed branch offset |
| skp_reg | input | 8 | Register or I/O value tested by a bit skip |
| skp_bit | input | 3 | Bit tested by a bit skip |
| skp_pol | input | 1 | Bit value that causes the skip |
| cmp_a | input | 8 | First compare-skip operand |
| cmp_b | input | 8 | Second compare-skip operand |
| next_is_long | input | 1 | Following instruction is two words |
| pc_in | input | PCW | Program counter of the current instruction |
| sreg | output | 8 | Flag register |
| taken | output | 1 | Branch or skip taken |
| pc_next | output | PCW | Next program counter |
| cycles | output | 2 | Cycles spent by the instruction |

## Verification
The properties assume that `req_kind` and its operands are steady within a cycle. They also assume that a flag-update command is applied for exactly one cycle and then dropped, so every update property compares one edge against the values seen one cycle earlier. The stimulus changes inputs only on the falling clock edge and returns every enable to zero between operations unless a test deliberately combines two of them. Offsets cover positive, negative and wrapping cases, and combined commands cover the override rules.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

  localparam int FLAG_W = 8;
  localparam int IDX_W  = $clog2(FLAG_W);
  localparam int IDX_I  = 7;
  localparam int IDX_T  = 6;

  typedef enum logic [1:0] {
    REQ_NONE     = 2'b00,
    REQ_BRANCH   = 2'b01,
    REQ_SKIP_BIT = 2'b10,
    REQ_SKIP_EQ  = 2'b11
  } req_kind_e;

  // Keep flags outside the mask, take new values inside it.
  function automatic logic [FLAG_W-1:0] f_merge(
    input logic [FLAG_W-1:0] old_v,
    input logic [FLAG_W-1:0] new_v,
    input logic [FLAG_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  // Replace one bit of a byte.
  function automatic logic [FLAG_W-1:0] f_put_bit(
    input logic [FLAG_W-1:0] v,
    input logic [IDX_W-1:0]  idx,
    input logic              b);
    logic [FLAG_W-1:0] r;
    r      = v;
    r[idx] = b;
    return r;
  endfunction

endpackage

// File: rtl/sbu_flag_reg.sv
module sbu_flag_reg
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_we,
  input  logic [FLAG_W-1:0] alu_mask,
  input  logic [FLAG_W-1:0] alu_flags,
  input  logic              bit_op_en,
  input  logic              bit_op_set,
  input  logic [IDX_W-1:0]  bit_op_idx,
  input  logic              tst_en,
  input  logic              tst_val,
  input  logic              reti_en,
  output logic              flags_written,
  output logic [FLAG_W-1:0] sreg
);

  logic [FLAG_W-1:0] sreg_d;

  assign flags_written = alu_we | bit_op_en | tst_en | reti_en;

  // Ordering sets priority: the explicit bit command is applied last.
  always_comb begin
    sreg_d = sreg;
    if (alu_we)    sreg_d = f_merge(sreg_d, alu_flags, alu_mask);
    if (tst_en)    sreg_d[IDX_T] = tst_val;
    if (reti_en)   sreg_d[IDX_I] = 1'b1;
    if (bit_op_en) sreg_d = f_put_bit(sreg_d, bit_op_idx, bit_op_set);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sreg <= '0;
    else        sreg <= sreg_d;
  end

endmodule

// File: rtl/sbu_cond_eval.sv
module sbu_cond_eval
  import sbu_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic [1:0]               req_kind,
  input  logic [FLAG_W-1:0]        sreg,
  input  logic [IDX_W-1:0]         br_idx,
  input  logic                     br_pol,
  input  logic [REG_W-1:0]         skp_reg,
  input  logic [$clog2(REG_W)-1:0] skp_bit,
  input  logic                     skp_pol,
  input  logic [REG_W-1:0]         cmp_a,
  input  logic [REG_W-1:0]         cmp_b,
  output logic                     is_branch,
  output logic                     is_skip,
  output logic                     cond_true
);

  req_kind_e kind;
  logic      flag_hit;
  logic      bit_hit;
  logic      eq_hit;

  assign kind      = req_kind_e'(req_kind);
  assign flag_hit  = (sreg[br_idx] == br_pol);
  assign bit_hit   = (skp_reg[skp_bit] == skp_pol);
  assign eq_hit    = (cmp_a == cmp_b);
  assign is_branch = (kind == REQ_BRANCH);
  assign is_skip   = (kind == REQ_SKIP_BIT) || (kind == REQ_SKIP_EQ);

  always_comb begin
    unique case (kind)
      REQ_BRANCH:   cond_true = flag_hit;
      REQ_SKIP_BIT: cond_true = bit_hit;
      REQ_SKIP_EQ:  cond_true = eq_hit;
      default:      cond_true = 1'b0;
    endcase
  end

endmodule

// File: rtl/sbu_pc_step.sv
module sbu_pc_step #(
  parameter int PCW  = 12,
  parameter int OFFW = 7
) (
  input  logic [PCW-1:0]  pc_in,
  input  logic [OFFW-1:0] br_off,
  input  logic            is_branch,
  input  logic            is_skip,
  input  logic            cond_true,
  input  logic            next_is_long,
  output logic            taken,
  output logic [PCW-1:0]  pc_next,
  output logic [1:0]      cycles
);

  localparam int EXT_W = PCW - OFFW;

  logic [PCW-1:0] off_ext;
  logic [PCW-1:0] skip_step;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{br_off[OFFW-1]}}, br_off};
    end else begin : g_trunc
      assign off_ext = br_off[PCW-1:0];
    end
  endgenerate

  assign skip_step = next_is_long ? PCW'(3) : PCW'(2);
  assign taken     = (is_branch | is_skip) & cond_true;

  always_comb begin
    pc_next = pc_in + PCW'(1);
    cycles  = 2'd1;
    if (is_branch && cond_true) begin
      pc_next = pc_in + off_ext + PCW'(1);
      cycles  = 2'd2;
    end else if (is_skip && cond_true) begin
      pc_next = pc_in + skip_step;
      cycles  = next_is_long ? 2'd3 : 2'd2;
    end
  end

endmodule

// File: rtl/sreg_branch_unit.sv
module sreg_branch_unit
  import sbu_pkg::*;
#(
  parameter int PCW  = 12,
  parameter int OFFW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alu_we,
  input  logic [7:0]     alu_mask,
  input  logic [7:0]     alu_flags,
  input  logic           bit_op_en,
  input  logic           bit_op_set,
  input  logic [2:0]     bit_op_idx,
  input  logic           tst_en,
  input  logic [7:0]     tst_reg,
  input  logic [2:0]     tst_bit,
  input  logic           reti_en,
  input  logic [7:0]     blt_reg,
  input  logic [2:0]     blt_bit,
  output logic [7:0]     blt_out,
  input  logic [1:0]     req_kind,
  input  logic [2:0]     br_idx,
  input  logic           br_pol,
  input  logic [OFFW-1:0] br_off,
  input  logic [7:0]     skp_reg,
  input  logic [2:0]     skp_bit,
  input  logic           skp_pol,
  input  logic [7:0]     cmp_a,
  input  logic [7:0]     cmp_b,
  input  logic           next_is_long,
  input  logic [PCW-1:0] pc_in,
  output logic [7:0]     sreg,
  output logic           taken,
  output logic [PCW-1:0] pc_next,
  output logic [1:0]     cycles
);

  logic tst_val;
  logic flags_written;
  logic is_branch;
  logic is_skip;
  logic cond_true;

  assign tst_val = tst_reg[tst_bit];
  assign blt_out = f_put_bit(blt_reg, blt_bit, sreg[IDX_T]);

  sbu_flag_reg u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .alu_we        (alu_we),
    .alu_mask      (alu_mask),
    .alu_flags     (alu_flags),
    .bit_op_en     (bit_op_en),
    .bit_op_set    (bit_op_set),
    .bit_op_idx    (bit_op_idx),
    .tst_en        (tst_en),
    .tst_val       (tst_val),
    .reti_en       (reti_en),
    .flags_written (flags_written),
    .sreg          (sreg)
  );

  sbu_cond_eval #(.REG_W(8)) u_cond (
    .req_kind  (req_kind),
    .sreg      (sreg),
    .br_idx    (br_idx),
    .br_pol    (br_pol),
    .skp_reg   (skp_reg),
    .skp_bit   (skp_bit),
    .skp_pol   (skp_pol),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .is_branch (is_branch),
    .is_skip   (is_skip),
    .cond_true (cond_true)
  );

  sbu_pc_step #(.PCW(PCW), .OFFW(OFFW)) u_step (
    .pc_in        (pc_in),
    .br_off       (br_off),
    .is_branch    (is_branch),
    .is_skip      (is_skip),
    .cond_true    (cond_true),
    .next_is_long (next_is_long),
    .taken        (taken),
    .pc_next      (pc_next),
    .cycles       (cycles)
  );

endmodule

// File: rtl/sbu_checker.sv
module sbu_checker #(
  parameter int PCW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           alu_we,
  input logic [7:0]     alu_mask,
  input logic [7:0]     alu_flags,
  input logic           bit_op_en,
  input logic           bit_op_set,
  input logic [2:0]     bit_op_idx,
  input logic           tst_en,
  input logic [7:0]     tst_reg,
  input logic [2:0]     tst_bit,
  input logic           reti_en,
  input logic [7:0]     blt_reg,
  input logic [7:0]     blt_out,
  input logic [1:0]     req_kind,
  input logic [PCW-1:0] pc_in,
  input logic [7:0]     sreg,
  input logic           taken,
  input logic [PCW-1:0] pc_next,
  input logic [1:0]     cycles,
  input logic           flags_written
);

  logic [PCW-1:0] pc_delta;
  logic           only_alu;
  logic           t_store_free;
  logic           i_set_free;

  assign pc_delta     = pc_next - pc_in;
  assign only_alu     = alu_we & ~bit_op_en & ~tst_en & ~reti_en;
  assign t_store_free = tst_en & ~(bit_op_en && bit_op_idx == 3'd6);
  assign i_set_free   = reti_en & ~(bit_op_en && bit_op_idx == 3'd7);

  AST_ALU_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    only_alu |=> sreg == (($past(sreg) & ~$past(alu_mask)) | ($past(alu_flags) & $past(alu_mask)))); // R2
  AST_BITOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_op_en |=> sreg[$past(bit_op_idx)] == $past(bit_op_set)); // R3
  AST_T_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    t_store_free |=> sreg[6] == $past(tst_reg[tst_bit])); // R4
  AST_BLT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(blt_out ^ blt_reg) <= 1); // R5
  AST_RETI_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    i_set_free |=> sreg[7]); // R6
  AST_BR_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == 2'b01) |-> (cycles == (taken ? 2'd2 : 2'd1))); // R8
  AST_SKIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    req_kind[1] |-> (pc_delta == PCW'(cycles))); // R10
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == 2'b00) |-> (!taken && cycles == 2'd1 && pc_delta == PCW'(1))); // R11
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_written |=> $stable(sreg)); // R12

endmodule

bind sreg_branch_unit sbu_checker #(.PCW(PCW)) u_chk (.*);

// File: tb/tb_sreg_branch_unit.sv
module tb_sreg_branch_unit;

  localparam int PCW = 12;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           alu_we, bit_op_en, bit_op_set, tst_en, reti_en;
  logic [7:0]     alu_mask, alu_flags, tst_reg, blt_reg, skp_reg, cmp_a, cmp_b;
  logic [2:0]     bit_op_idx, tst_bit, blt_bit, br_idx, skp_bit;
  logic [1:0]     req_kind;
  logic           br_pol, skp_pol, next_is_long;
  logic [6:0]     br_off;
  logic [PCW-1:0] pc_in;
  logic [7:0]     blt_out, sreg;
  logic           taken;
  logic [PCW-1:0] pc_next;
  logic [1:0]     cycles;

  always #4 clk = ~clk;

  sreg_branch_unit #(.PCW(PCW)) dut (.*);

  typedef struct packed {
    logic           tk;
    logic [PCW-1:0] pc;
    logic [1:0]     cy;
    logic [7:0]     fl;
    logic [7:0]     bl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  logic [7:0] model_fl;

  task automatic idle_inputs();
    alu_we = 0; alu_mask = 0; alu_flags = 0;
    bit_op_en = 0; bit_op_set = 0; bit_op_idx = 0;
    tst_en = 0; tst_reg = 0; tst_bit = 0; reti_en = 0;
    blt_reg = 0; blt_bit = 0; req_kind = 2'b00;
    br_idx = 0; br_pol = 0; br_off = 0;
    skp_reg = 0; skp_bit = 0; skp_pol = 0;
    cmp_a = 0; cmp_b = 0; next_is_long = 0; pc_in = 12'h100;
  endtask

  // Driver: predicts outputs from the current inputs, then advances the flag model.
  task automatic push_exp(input string tag);
    exp_t e;
    logic cond;
    int   off_i;
    int   step;
    cond = 1'b0;
    case (req_kind)
      2'b01: cond = (model_fl[br_idx] === br_pol);
      2'b10: cond = (skp_reg[skp_bit] === skp_pol);
      2'b11: cond = (cmp_a === cmp_b);
      default: cond = 1'b0;
    endcase
    off_i = br_off[6] ? int'(br_off) - 128 : int'(br_off);
    step  = 1;
    e.cy  = 2'd1;
    if (req_kind == 2'b01 && cond) begin
      step = off_i + 1; e.cy = 2'd2;
    end else if (req_kind[1] && cond) begin
      step = next_is_long ? 3 : 2; e.cy = next_is_long ? 2'd3 : 2'd2;
    end
    e.tk = cond;
    e.pc = PCW'((int'(pc_in) + step + 4096) % 4096);
    e.fl = model_fl;
    e.bl = blt_reg;
    e.bl[blt_bit] = model_fl[6];
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int i = 0; i < 8; i++)
      if (alu_we && alu_mask[i]) model_fl[i] = alu_flags[i];
    if (tst_en)    model_fl[6] = tst_reg[tst_bit];
    if (reti_en)   model_fl[7] = 1'b1;
    if (bit_op_en) model_fl[bit_op_idx] = bit_op_set;
  endtask

  task automatic cmp_field(input string tag, input string name, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, expv);
    end
  endtask

  // Monitor: pops predictions and compares them with the outputs.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp_field(t, "taken",   int'(taken),   int'(e.tk));
        cmp_field(t, "pc_next", int'(pc_next), int'(e.pc));
        cmp_field(t, "cycles",  int'(cycles),  int'(e.cy));
        cmp_field(t, "sreg",    int'(sreg),    int'(e.fl));
        cmp_field(t, "blt_out", int'(blt_out), int'(e.bl));
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  task automatic op(input string tag);
    push_exp(tag);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    model_fl = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 and R11: cleared flags, no request
    op("R1");
    op("R11");
    // R2: masked ALU writes
    alu_we = 1; alu_mask = 8'h0F; alu_flags = 8'hA5; op("R2");
    alu_we = 1; alu_mask = 8'hF0; alu_flags = 8'h3C; op("R2");
    alu_we = 1; alu_mask = 8'hFF; alu_flags = 8'h5A; op("R2");
    // R12: nothing written, flags hold
    op("R12");
    op("R12");
    // R3: bit command wins over ALU in the same cycle
    alu_we = 1; alu_mask = 8'h80; alu_flags = 8'h00;
    bit_op_en = 1; bit_op_set = 1; bit_op_idx = 3'd7; op("R3");
    alu_we = 1; alu_mask = 8'h08; alu_flags = 8'h08;
    bit_op_en = 1; bit_op_set = 0; bit_op_idx = 3'd3; op("R3");
    bit_op_en = 1; bit_op_set = 1; bit_op_idx = 3'd0; op("R3");
    // R4: bit store into T, then bit command overriding T
    tst_en = 1; tst_reg = 8'h10; tst_bit = 3'd4; op("R4");
    tst_en = 1; tst_reg = 8'hEF; tst_bit = 3'd4; op("R4");
    tst_en = 1; tst_reg = 8'h01; tst_bit = 3'd0;
    bit_op_en = 1; bit_op_set = 0; bit_op_idx = 3'd6; op("R4");
    tst_en = 1; tst_reg = 8'h01; tst_bit = 3'd0; op("R4");
    // R5: bit load with T = 1 and T = 0; flags unchanged
    blt_reg = 8'h00; blt_bit = 3'd3; op("R5");
    blt_reg = 8'hFF; blt_bit = 3'd7; op("R5");
    bit_op_en = 1; bit_op_set = 0; bit_op_idx = 3'd6; op("R5");
    blt_reg = 8'hFF; blt_bit = 3'd2; op("R5");
    // R6: return from interrupt after clearing I
    bit_op_en = 1; bit_op_set = 0; bit_op_idx = 3'd7; op("R6");
    reti_en = 1; op("R6");
    op("R6");
    // R7 and R8: branches on set and clear flags, both offset signs
    alu_we = 1; alu_mask = 8'h3F; alu_flags = 8'h13; op("R7");
    req_kind = 2'b01; br_idx = 3'd1; br_pol = 1; br_off = 7'd10; op("R7");
    req_kind = 2'b01; br_idx = 3'd1; br_pol = 0; br_off = 7'd10; op("R8");
    req_kind = 2'b01; br_idx = 3'd0; br_pol = 1; br_off = 7'h7F; op("R7");
    req_kind = 2'b01; br_idx = 3'd4; br_pol = 1; br_off = 7'h40; op("R7");
    req_kind = 2'b01; br_idx = 3'd4; br_pol = 0; br_off = 7'h40; op("R8");
    req_kind = 2'b01; br_idx = 3'd2; br_pol = 0; br_off = 7'd5;
    pc_in = 12'hFFD; op("R7");
    req_kind = 2'b01; br_idx = 3'd7; br_pol = 1; br_off = 7'h3F; op("R8");
    // R9 and R10: bit skips, equal skips, short and long followers
    req_kind = 2'b10; skp_reg = 8'h80; skp_bit = 3'd7; skp_pol = 1; op("R9");
    req_kind = 2'b10; skp_reg = 8'h80; skp_bit = 3'd7; skp_pol = 1;
    next_is_long = 1; op("R10");
    req_kind = 2'b10; skp_reg = 8'h80; skp_bit = 3'd6; skp_pol = 1;
    next_is_long = 1; op("R10");
    req_kind = 2'b10; skp_reg = 8'h80; skp_bit = 3'd6; skp_pol = 0; op("R9");
    req_kind = 2'b11; cmp_a = 8'h42; cmp_b = 8'h42; next_is_long = 1; op("R9");
    req_kind = 2'b11; cmp_a = 8'h42; cmp_b = 8'h43; op("R10");
    req_kind = 2'b11; cmp_a = 8'h00; cmp_b = 8'h00; pc_in = 12'hFFF; op("R10");
    op("R11");
    repeat (3) @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule